// File: doc/BRIEF.md
# Bit Test and Modify Unit

This block tests one bit of an operand and optionally sets, clears or complements it, without a variable-index bit selector. It works in four clock steps. It captures the request. It rotates the operand right so that the addressed bit lands in position 0. It copies that bit to carry and edits it there. It then rotates the word back by the complementary amount. One rotator serves both rotations.

For operands held in memory, the bit index is a signed number that may reach past the operand. The unit splits it into two parts: a signed byte offset, aligned to the operand size, that the caller adds to the operand address, and an in-operand bit position. Register operands use the index modulo the width and produce no offset. The unit performs no memory access. It raises a write-enable output at completion only when the operand was actually modified.

Top module: `bit_test_unit`

## Requirements
- R1: While reset is asserted and right after it, busy, done, writeEn and carryOut are 0, and result and addrOffset are all zeros.
- R2: A start seen while idle is accepted on that clock edge. busy is then high for the next three cycles. done is high for exactly one cycle, in the fourth cycle after acceptance.
- R3: In every operation, carryOut at completion equals the original value of the addressed bit.
- R4: opSel encoding: 00 test (operand returned unchanged), 01 set the bit, 10 clear the bit, 11 complement the bit. All other bits of result equal the operand.
- R5: writeEn is high in the done cycle when opSel was not 00, and is low at all other times.
- R6: For register operands (isMem=0), the bit position is the index modulo the operand width (index bits [4:0] for 32-bit, [3:0] for 16-bit), and addrOffset is 0.
- R7: For memory operands (isMem=1), the bit position is the index modulo the width. addrOffset is the index arithmetically shifted right by 3, with its low 2 bits (32-bit) or low bit (16-bit) cleared, so that offset*8 + position equals the signed index. Example: index 35 on a 32-bit operand gives offset 4 and position 3.
- R8: With sizeFull=0, the operation acts on bits [15:0] only, and result[31:16] equals operand[31:16].
- R9: A start asserted while busy is ignored. The running operation completes with its own inputs, and no extra operation follows.
- R10: A start asserted in the done cycle is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new operation |
| operand | input | DATA_W | Value to test and modify |
| bitIndex | input | DATA_W | Bit index (signed for memory operands) |
| opSel | input | 2 | Operation: 00 test, 01 set, 10 clear, 11 complement |
| sizeFull | input | 1 | 1: full-width operand, 0: half-width operand |
| isMem | input | 1 | 1: memory operand (offset produced), 0: register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| writeEn | output | 1 | Result must be stored |
| carryOut | output | 1 | Original value of the addressed bit |
| result | output | DATA_W | Operand after the edit |
| addrOffset | output | DATA_W | Signed, size-aligned byte offset |

## Verification
The done pulse of one operation and the acceptance of the next request fall in the same cycle. Every vector in the bench raises start in the done cycle of the previous one. Each such request must be accepted with busy high one cycle later, while the finishing outputs still match their own vector. A separate case holds start high through the busy window with different data. The first operation's results must be unaffected, and no second done may follow.

// File: rtl/btm_pkg.sv
package btm_pkg;

  typedef enum logic [1:0] {
    OP_TEST  = 2'b00,
    OP_SET   = 2'b01,
    OP_CLEAR = 2'b10,
    OP_FLIP  = 2'b11
  } bitOp_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ALIGN   = 2'd1,
    ST_EDIT    = 2'd2,
    ST_RESTORE = 2'd3
  } seqState_t;

  // Strobes from the sequencer to the datapath, at most one high per cycle
  typedef struct packed {
    logic capture;
    logic alignRot;
    logic editBit;
    logic restoreRot;
  } seqStrobe_t;

  function automatic logic editedBit(input bitOp_t op, input logic oldBit);
    case (op)
      OP_SET:   editedBit = 1'b1;
      OP_CLEAR: editedBit = 1'b0;
      OP_FLIP:  editedBit = ~oldBit;
      default:  editedBit = oldBit;
    endcase
  endfunction

endpackage

// File: rtl/bit_rotator.sv
// Logarithmic right rotator; rotates the full word or only its lower half.
module bit_rotator #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         din,
  input  logic [$clog2(DATA_W)-1:0] amt,
  input  logic                      fullMode,
  output logic [DATA_W-1:0]         dout
);
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int HALF_W = DATA_W / 2;

  logic [CNT_W:0][DATA_W-1:0] stage;

  assign stage[0] = din;

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [DATA_W-1:0] fullRot;
    logic [DATA_W-1:0] halfRot;

    assign fullRot = {stage[k][SH-1:0], stage[k][DATA_W-1:SH]};

    if (SH < HALF_W) begin : g_half
      assign halfRot = {stage[k][DATA_W-1:HALF_W], stage[k][SH-1:0], stage[k][HALF_W-1:SH]};
    end else begin : g_nohalf
      assign halfRot = stage[k];
    end

    assign stage[k+1] = amt[k] ? (fullMode ? fullRot : halfRot) : stage[k];
  end

  assign dout = stage[CNT_W];
endmodule

// File: rtl/bit_test_ctrl.sv
module bit_test_ctrl
  import btm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output seqStrobe_t strobe
);
  seqState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.capture = 1'b1;
          stateNext      = ST_ALIGN;
        end
      end
      ST_ALIGN: begin
        strobe.alignRot = 1'b1;
        stateNext       = ST_EDIT;
      end
      ST_EDIT: begin
        strobe.editBit = 1'b1;
        stateNext      = ST_RESTORE;
      end
      default: begin
        strobe.restoreRot = 1'b1;
        stateNext         = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.restoreRot;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/bit_test_dpath.sv
module bit_test_dpath
  import btm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] bitIndex,
  input  logic [1:0]        opSel,
  input  logic              sizeFull,
  input  logic              isMem,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              writeEn,
  output logic [DATA_W-1:0] addrOffset
);
  localparam int CNT_W      = $clog2(DATA_W);
  localparam int HALF_W     = DATA_W / 2;
  localparam int FULL_BYTES = DATA_W / 8;
  localparam int HALF_BYTES = HALF_W / 8;
  localparam logic [DATA_W-1:0] FULL_MASK = ~(DATA_W'(FULL_BYTES - 1));
  localparam logic [DATA_W-1:0] HALF_MASK = ~(DATA_W'(HALF_BYTES - 1));
  localparam logic [CNT_W-1:0]  HALF_POS  = CNT_W'(HALF_W - 1);

  logic [DATA_W-1:0] workReg;
  logic [CNT_W-1:0]  posReg;
  logic [DATA_W-1:0] offPend;
  bitOp_t            opReg;
  logic              fullReg;
  logic              cfWork;

  logic [DATA_W-1:0] byteIdx;
  logic [DATA_W-1:0] alignedOff;
  logic [CNT_W-1:0]  newPos;
  logic [CNT_W-1:0]  backAmt;
  logic [CNT_W-1:0]  rotAmt;
  logic [DATA_W-1:0] rotOut;

  // Signed index to byte offset, aligned to the operand size
  assign byteIdx    = $unsigned($signed(bitIndex) >>> 3);
  assign alignedOff = byteIdx & (sizeFull ? FULL_MASK : HALF_MASK);
  assign newPos     = sizeFull ? bitIndex[CNT_W-1:0] : (bitIndex[CNT_W-1:0] & HALF_POS);

  // Rotating right by (width - pos) undoes the first rotation
  assign backAmt = fullReg ? (CNT_W'(0) - posReg) : ((CNT_W'(0) - posReg) & HALF_POS);
  assign rotAmt  = strobe.restoreRot ? backAmt : posReg;

  bit_rotator #(.DATA_W(DATA_W)) i_rot (
    .din     (workReg),
    .amt     (rotAmt),
    .fullMode(fullReg),
    .dout    (rotOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workReg    <= '0;
      posReg     <= '0;
      offPend    <= '0;
      opReg      <= OP_TEST;
      fullReg    <= 1'b1;
      cfWork     <= 1'b0;
      result     <= '0;
      carryOut   <= 1'b0;
      writeEn    <= 1'b0;
      addrOffset <= '0;
    end else begin
      writeEn <= 1'b0;
      if (strobe.capture) begin
        workReg <= operand;
        posReg  <= newPos;
        offPend <= isMem ? alignedOff : '0;
        opReg   <= bitOp_t'(opSel);
        fullReg <= sizeFull;
      end
      if (strobe.alignRot) begin
        workReg <= rotOut;
      end
      if (strobe.editBit) begin
        cfWork     <= workReg[0];
        workReg[0] <= editedBit(opReg, workReg[0]);
      end
      if (strobe.restoreRot) begin
        result     <= rotOut;
        carryOut   <= cfWork;
        addrOffset <= offPend;
        writeEn    <= (opReg != OP_TEST);
      end
    end
  end
endmodule

// File: rtl/bit_test_unit.sv
module bit_test_unit
  import btm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] bitIndex,
  input  logic [1:0]        opSel,
  input  logic              sizeFull,
  input  logic              isMem,
  output logic              busy,
  output logic              done,
  output logic              writeEn,
  output logic              carryOut,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] addrOffset
);
  seqStrobe_t strobe;

  bit_test_ctrl i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .busy  (busy),
    .done  (done),
    .strobe(strobe)
  );

  bit_test_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .operand   (operand),
    .bitIndex  (bitIndex),
    .opSel     (opSel),
    .sizeFull  (sizeFull),
    .isMem     (isMem),
    .result    (result),
    .carryOut  (carryOut),
    .writeEn   (writeEn),
    .addrOffset(addrOffset)
  );
endmodule

// File: rtl/bit_test_chk.sv
module bit_test_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [DATA_W-1:0] operand,
  input logic [1:0]        opSel,
  input logic              sizeFull,
  input logic              isMem,
  input logic              busy,
  input logic              done,
  input logic              writeEn,
  input logic [DATA_W-1:0] result,
  input logic [DATA_W-1:0] addrOffset
);
  localparam int HALF_W = DATA_W / 2;

  logic              accept;
  logic [DATA_W-1:0] opndL;
  logic [1:0]        opL;
  logic              fullL;
  logic              memL;

  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opndL <= '0;
      opL   <= 2'b00;
      fullL <= 1'b1;
      memL  <= 1'b0;
    end else if (accept) begin
      opndL <= operand;
      opL   <= opSel;
      fullL <= sizeFull;
      memL  <= isMem;
    end
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(accept, 4));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy);

  // R5
  write_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeEn |-> (done && opL != 2'b00));

  // R4
  test_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && opL == 2'b00) |-> (result == opndL));

  // R6
  reg_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !memL) |-> (addrOffset == '0));

  // R8
  half_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fullL) |-> (result[DATA_W-1:HALF_W] == opndL[DATA_W-1:HALF_W]));
endmodule

bind bit_test_unit bit_test_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .operand   (operand),
  .opSel     (opSel),
  .sizeFull  (sizeFull),
  .isMem     (isMem),
  .busy      (busy),
  .done      (done),
  .writeEn   (writeEn),
  .result    (result),
  .addrOffset(addrOffset)
);

// File: tb/test_bit_test_unit.sv
`timescale 1ns/1ps
module test_bit_test_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] operand = '0;
  logic [31:0] bitIndex = '0;
  logic [1:0]  opSel = 2'b00;
  logic        sizeFull = 1'b1;
  logic        isMem = 1'b0;
  logic        busy, done, writeEn, carryOut;
  logic [31:0] result, addrOffset;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bit_test_unit #(.DATA_W(32)) i_bit_test_unit (
    .clk(clk), .rstN(rstN), .start(start), .operand(operand), .bitIndex(bitIndex),
    .opSel(opSel), .sizeFull(sizeFull), .isMem(isMem), .busy(busy), .done(done),
    .writeEn(writeEn), .carryOut(carryOut), .result(result), .addrOffset(addrOffset)
  );

  // {opSel, sizeFull, isMem, operand, bitIndex}
  localparam logic [67:0] VECS [0:11] = '{
    {2'b00, 1'b1, 1'b0, 32'hA5A5_5A5A, 32'd0},
    {2'b01, 1'b1, 1'b0, 32'h0000_0000, 32'd31},
    {2'b10, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'd63},
    {2'b11, 1'b1, 1'b0, 32'h1234_5678, 32'd7},
    {2'b00, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'd100},
    {2'b01, 1'b1, 1'b1, 32'h0F0F_0F0F, 32'hFFFF_FFF0},
    {2'b10, 1'b1, 1'b1, 32'h8000_0000, 32'h8000_001F},
    {2'b11, 1'b0, 1'b0, 32'hCAFE_0001, 32'd17},
    {2'b01, 1'b0, 1'b1, 32'h5555_0000, 32'hFFFF_FFEF},
    {2'b10, 1'b0, 1'b1, 32'h1111_FFFF, 32'd15},
    {2'b11, 1'b1, 1'b1, 32'h0000_0001, 32'd0},
    {2'b00, 1'b0, 1'b0, 32'hFFFF_8000, 32'd47}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge of the done cycle.
  task automatic runOp(input logic [1:0] op, input logic full, input logic mem,
                       input logic [31:0] opd, input logic [31:0] idx);
    int          pos;
    logic        oldBit, newBit;
    logic [31:0] expRes, expOff;
    pos    = full ? int'(idx[4:0]) : int'(idx[3:0]);
    oldBit = opd[pos];
    case (op)
      2'b01:   newBit = 1'b1;
      2'b10:   newBit = 1'b0;
      2'b11:   newBit = ~oldBit;
      default: newBit = oldBit;
    endcase
    expRes      = opd;
    expRes[pos] = newBit;
    expOff      = mem ? ($unsigned($signed(idx) >>> 3) & (full ? 32'hFFFF_FFFC : 32'hFFFF_FFFE)) : 32'd0;

    opSel = op; sizeFull = full; isMem = mem; operand = opd; bitIndex = idx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after accept (R10 when back to back)", {31'd0, busy}, 32'd1);
    check("R2 no early done", {31'd0, done}, 32'd0);
    repeat (3) @(negedge clk);
    check("R2 done in fourth cycle", {31'd0, done}, 32'd1);
    check(full ? "R4 result" : "R8 half-width result", result, expRes);
    check("R3 carry", {31'd0, carryOut}, {31'd0, oldBit});
    check("R5 write enable", {31'd0, writeEn}, {31'd0, op != 2'b00});
    check(mem ? "R7 memory offset" : "R6 register offset", addrOffset, expOff);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 writeEn", {31'd0, writeEn}, 32'd0);
    check("R1 carry", {31'd0, carryOut}, 32'd0);
    check("R1 result", result, 32'd0);
    check("R1 offset", addrOffset, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {31'd0, busy}, 32'd0);

    for (int i = 0; i < 12; i++) begin
      runOp(VECS[i][67:66], VECS[i][65], VECS[i][64], VECS[i][63:32], VECS[i][31:0]);
    end

    // R7 hand-worked: index 35 on a 32-bit operand -> offset 4, bit 3
    runOp(2'b01, 1'b1, 1'b1, 32'h0000_0008, 32'd35);
    check("R7 index 35 offset", addrOffset, 32'd4);
    check("R7 index 35 bit 3 carry", {31'd0, carryOut}, 32'd1);
    // R7 index -1 -> offset -4, bit 31
    runOp(2'b10, 1'b1, 1'b1, 32'h8000_0001, 32'hFFFF_FFFF);
    check("R7 index -1 offset", addrOffset, 32'hFFFF_FFFC);
    check("R7 index -1 result", result, 32'h0000_0001);
    // R7 16-bit, index -17 -> offset -4, bit 15
    runOp(2'b11, 1'b0, 1'b1, 32'hAAAA_0000, 32'hFFFF_FFEF);
    check("R7 half index -17 offset", addrOffset, 32'hFFFF_FFFC);
    check("R8 half index -17 result", result, 32'hAAAA_8000);
    // R6 register index 37 -> bit 5, no offset
    runOp(2'b11, 1'b1, 1'b0, 32'h0000_0000, 32'd37);
    check("R6 register wrap result", result, 32'h0000_0020);

    // R9: start held high with other data while busy
    opSel = 2'b01; sizeFull = 1'b1; isMem = 1'b0; operand = 32'h0000_0000; bitIndex = 32'd4; start = 1'b1;
    @(negedge clk);
    operand = 32'hFFFF_FFFF; opSel = 2'b10; bitIndex = 32'd9;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R9 done of first op", {31'd0, done}, 32'd1);
    check("R9 result from first inputs", result, 32'h0000_0010);
    @(negedge clk);
    check("R9 no extra operation busy", {31'd0, busy}, 32'd0);
    check("R9 done not repeated", {31'd0, done}, 32'd0);
    check("R5 writeEn low outside done", {31'd0, writeEn}, 32'd0);
    repeat (4) @(negedge clk);
    check("R9 no late done", {31'd0, done}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule